// File: doc/BRIEF.md
# Lamp Channel Strike and Fault Supervisor

This block sequences a set of lamp channels through their life cycle: it waits for healthy supplies, strikes each lamp, supervises it while it runs, and handles every lamp problem with an automatic retry or a latched shutdown. Each channel holds its own state machine. It counts lamp cycles from a shared lamp-cycle tick and reads digital comparator flags for lamp current present, lamp current below the lamp-out level, overcurrent, overvoltage and regulation reached.

Each channel drives a gate enable for its drive stage. It also drives the frequency increase, in percent, that the lamp oscillator applies while the lamp strikes, and a fault flag. A small combiner merges the flags into one active-low fault line. When configured to do so, it stops every channel as soon as any channel has latched a fault. The strike timeout, the retry behaviour, the overcurrent response and the strike boost are shared configuration inputs. The oscillator, the comparators and the duty regulation loop sit outside the block.

Top module: `lamp_strike_sup`

## Requirements
- R1: A channel turns its gate on only when `vcc_ok`, `inv_ok` and its `ch_en` bit are all 1. If any of the three is 0, the channel returns to idle with its gate off on the next clock.
- R2: The strike lasts at most (`tmo_sel`+1) x TMO_UNIT lamp ticks when `low_range`=0, and half that when `low_range`=1. If no lamp current is seen by then, the gate turns off and fault handling starts.
- R3: In the run state, when `lamp_out` is held for the same timeout count of consecutive ticks, the gate turns off and fault handling starts.
- R4: Overvoltage causes a fault only after OV_CYC consecutive ticks with `over_volt` high. A shorter burst has no effect.
- R5: With `oc_en`=1, overcurrent during strike or run latches the channel on the next clock, and the channel never retries. With `oc_en`=0, overcurrent is ignored.
- R6: With `autoretry`=1, a faulted channel keeps its gate off for RETRY_CYC ticks and then strikes again. The FAULT_LIMIT-th consecutive fault (15 by default) latches the channel.
- R7: With `autoretry`=0, the first fault latches the channel.
- R8: When `regulated` is high in the run state, the channel's fault flag and its fault count are cleared.
- R9: A latched channel stays latched, with its flag set, until a supply flag or its `ch_en` bit goes low. That clears the flag and the count.
- R10: During strike, the channel's 7-bit boost field is 0, 14, 23, 33, 46, 60, 78 or 100 for `boost_sel` codes 0 to 7. Outside strike, including once lamp current is seen, the field is 0. Channel n uses `boost_pct` bits [7n+6:7n].
- R11: With `fault_all`=0, a latched channel stops only itself. With `fault_all`=1, any latched channel turns off the gates of all other channels and holds them idle.
- R12: `fault_n` is 0 exactly when at least one channel's `ch_fault` flag is set. A flag is set from the first fault until it is cleared under R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Device supply above its lockout level |
| inv_ok | input | 1 | Inverter supply monitor above its threshold |
| lamp_tick | input | 1 | One pulse per lamp cycle |
| ch_en | input | NCH | Per-channel enable |
| lamp_on | input | NCH | Lamp current detected |
| lamp_out | input | NCH | Lamp current below lamp-out level |
| over_cur | input | NCH | Lamp overcurrent comparator |
| over_volt | input | NCH | Overvoltage comparator |
| regulated | input | NCH | Lamp current has reached its regulation level |
| tmo_sel | input | 2 | Timeout multiple select |
| low_range | input | 1 | Low lamp-frequency range, halves timeouts |
| autoretry | input | 1 | Retry after a fault instead of latching |
| oc_en | input | 1 | Overcurrent detection enable |
| fault_all | input | 1 | A latched fault stops all channels |
| boost_sel | input | 3 | Strike frequency boost code |
| gate_en | output | NCH | Gate drive enable per channel |
| boost_pct | output | NCH*7 | Strike frequency increase in percent per channel |
| ch_fault | output | NCH | Per-channel fault flag |
| fault_n | output | 1 | Active-low combined fault |

## Verification
The assertions check, on every cycle, several rules. A lost supply or enable forces idle on the next clock. An active overcurrent with detection enabled always lands in the latched state. A latched channel stays there while its supplies hold. The retry wait counter never passes its limit. A fault flag falls only after regulation or a supply or enable drop. Only the bench scenarios can show the actual durations: the strike and lamp-out timeouts for each select and range, the overvoltage window, and the wait between attempts. They also show that exactly fifteen attempts occur before the latch, the boost table values, and the cross-channel shutdown.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRIKE,
        ST_RUN,
        ST_WAIT,
        ST_LATCH
    } ch_state_t;

    typedef struct packed {
        logic [1:0] tmo_sel;
        logic       low_range;
        logic       autoretry;
        logic       oc_en;
        logic [2:0] boost_sel;
    } ch_cfg_t;

    typedef struct packed {
        logic lamp_on;
        logic lamp_out;
        logic over_cur;
        logic over_volt;
        logic regulated;
    } ch_sense_t;

    localparam int BOOST_W = 7;

    function automatic logic [BOOST_W-1:0] boost_percent(input logic [2:0] code);
        logic [BOOST_W-1:0] pct;
        case (code)
            3'd0:    pct = 7'd0;
            3'd1:    pct = 7'd14;
            3'd2:    pct = 7'd23;
            3'd3:    pct = 7'd33;
            3'd4:    pct = 7'd46;
            3'd5:    pct = 7'd60;
            3'd6:    pct = 7'd78;
            default: pct = 7'd100;
        endcase
        return pct;
    endfunction

    function automatic int unsigned timeout_ticks(input logic [1:0] sel,
                                                  input logic low,
                                                  input int unsigned unit);
        int unsigned full;
        full = (32'(sel) + 32'd1) * unit;
        return low ? (full >> 1) : full;
    endfunction

endpackage

// File: rtl/lcs_fault_combine.sv
module lcs_fault_combine #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] latched,
    input  logic [NCH-1:0] flags,
    input  logic           fault_all,
    output logic           kill,
    output logic           fault_n
);
    assign kill    = fault_all && (|latched);
    assign fault_n = ~(|flags);
endmodule

// File: rtl/lcs_channel.sv
module lcs_channel
    import lcs_pkg::*;
#(
    parameter int TMO_UNIT    = 32768,
    parameter int RETRY_CYC   = 1024,
    parameter int OV_CYC      = 64,
    parameter int FAULT_LIMIT = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_ok,
    input  logic                kill,
    input  logic                tick,
    input  ch_sense_t           sense,
    input  ch_cfg_t             cfg,
    output logic                gate_en,
    output logic [BOOST_W-1:0]  boost_pct,
    output logic                fault_flag,
    output logic                latched
);
    localparam int CMAX = (4 * TMO_UNIT > RETRY_CYC) ? 4 * TMO_UNIT : RETRY_CYC;
    localparam int TW   = $clog2(CMAX + 1);
    localparam int OW   = $clog2(OV_CYC + 1);
    localparam int FW   = $clog2(FAULT_LIMIT + 1);

    ch_state_t        st;
    logic [TW-1:0]    tcnt;
    logic [OW-1:0]    ovc;
    logic [FW-1:0]    fcnt;
    logic [TW-1:0]    tmo_lim;
    logic             active, hard_fault, tmo_hit, ov_hit, soft_fault, last_try;

    assign tmo_lim    = TW'(timeout_ticks(cfg.tmo_sel, cfg.low_range, TMO_UNIT));
    assign active     = (st == ST_STRIKE) || (st == ST_RUN);
    assign hard_fault = active && cfg.oc_en && sense.over_cur;
    assign tmo_hit    = tick && (tcnt >= tmo_lim - TW'(1)) &&
                        ((st == ST_STRIKE) || sense.lamp_out);
    assign ov_hit     = tick && sense.over_volt && (ovc == OW'(OV_CYC - 1));
    assign soft_fault = active && (tmo_hit || ov_hit);
    assign last_try   = !cfg.autoretry || (fcnt >= FW'(FAULT_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_ok) begin
            st         <= ST_IDLE;
            tcnt       <= '0;
            ovc        <= '0;
            fcnt       <= '0;
            fault_flag <= 1'b0;
        end else if (kill && st != ST_LATCH) begin
            st   <= ST_IDLE;
            tcnt <= '0;
            ovc  <= '0;
        end else if (hard_fault) begin
            st         <= ST_LATCH;
            fault_flag <= 1'b1;
        end else if (soft_fault) begin
            st         <= last_try ? ST_LATCH : ST_WAIT;
            fault_flag <= 1'b1;
            fcnt       <= fcnt + FW'(1);
            tcnt       <= '0;
            ovc        <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    st   <= ST_STRIKE;
                    tcnt <= '0;
                    ovc  <= '0;
                end
                ST_STRIKE: begin
                    if (tick) ovc <= sense.over_volt ? ovc + OW'(1) : '0;
                    if (sense.lamp_on) begin
                        st   <= ST_RUN;
                        tcnt <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_RUN: begin
                    if (tick) ovc <= sense.over_volt ? ovc + OW'(1) : '0;
                    if (!sense.lamp_out)  tcnt <= '0;
                    else if (tick)        tcnt <= tcnt + TW'(1);
                    if (sense.regulated) begin
                        fcnt       <= '0;
                        fault_flag <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (tcnt == TW'(RETRY_CYC - 1)) begin
                            st   <= ST_STRIKE;
                            tcnt <= '0;
                            ovc  <= '0;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
                default: st <= ST_LATCH;
            endcase
        end
    end

    assign gate_en   = active && !kill;
    assign boost_pct = (st == ST_STRIKE) ? boost_percent(cfg.boost_sel) : '0;
    assign latched   = (st == ST_LATCH);

    // R1: missing supply or enable forces idle
    a_r1_supply_gate: assert property (@(posedge clk) disable iff (rst)
        !run_ok |=> (st == ST_IDLE));

    // R5: enabled overcurrent always latches at once
    a_r5_oc_latch: assert property (@(posedge clk) disable iff (rst)
        (run_ok && !kill && cfg.oc_en && sense.over_cur && active) |=> (st == ST_LATCH));

    // R9: latch holds while supplies and enable hold
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LATCH && run_ok) |=> (st == ST_LATCH));

    // R6: retry wait counter stays inside its window
    a_r6_wait_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (tcnt < TW'(RETRY_CYC)));

    // R8: the flag only drops after regulation or a supply/enable loss
    a_r8_flag_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_flag) |-> ($past(sense.regulated) || !$past(run_ok)));

endmodule

// File: rtl/lamp_strike_sup.sv
module lamp_strike_sup
    import lcs_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int TMO_UNIT    = 32768,
    parameter int RETRY_CYC   = 1024,
    parameter int OV_CYC      = 64,
    parameter int FAULT_LIMIT = 15
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   vcc_ok,
    input  logic                   inv_ok,
    input  logic                   lamp_tick,
    input  logic [NCH-1:0]         ch_en,
    input  logic [NCH-1:0]         lamp_on,
    input  logic [NCH-1:0]         lamp_out,
    input  logic [NCH-1:0]         over_cur,
    input  logic [NCH-1:0]         over_volt,
    input  logic [NCH-1:0]         regulated,
    input  logic [1:0]             tmo_sel,
    input  logic                   low_range,
    input  logic                   autoretry,
    input  logic                   oc_en,
    input  logic                   fault_all,
    input  logic [2:0]             boost_sel,
    output logic [NCH-1:0]         gate_en,
    output logic [NCH*BOOST_W-1:0] boost_pct,
    output logic [NCH-1:0]         ch_fault,
    output logic                   fault_n
);
    ch_cfg_t        cfg;
    logic [NCH-1:0] latched;
    logic           kill;

    assign cfg = '{tmo_sel: tmo_sel, low_range: low_range, autoretry: autoretry,
                   oc_en: oc_en, boost_sel: boost_sel};

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ch_sense_t sense;
        assign sense = '{lamp_on: lamp_on[n], lamp_out: lamp_out[n],
                         over_cur: over_cur[n], over_volt: over_volt[n],
                         regulated: regulated[n]};

        lcs_channel #(
            .TMO_UNIT    (TMO_UNIT),
            .RETRY_CYC   (RETRY_CYC),
            .OV_CYC      (OV_CYC),
            .FAULT_LIMIT (FAULT_LIMIT)
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .run_ok     (vcc_ok && inv_ok && ch_en[n]),
            .kill       (kill),
            .tick       (lamp_tick),
            .sense      (sense),
            .cfg        (cfg),
            .gate_en    (gate_en[n]),
            .boost_pct  (boost_pct[n*BOOST_W +: BOOST_W]),
            .fault_flag (ch_fault[n]),
            .latched    (latched[n])
        );
    end

    lcs_fault_combine #(.NCH(NCH)) u_comb (
        .latched   (latched),
        .flags     (ch_fault),
        .fault_all (fault_all),
        .kill      (kill),
        .fault_n   (fault_n)
    );

    // R12: combined line low exactly when a flag is up
    a_r12_fault_line: assert property (@(posedge clk) disable iff (rst)
        (|ch_fault) |-> !fault_n);

endmodule

// File: tb/sim_lamp_strike_sup.sv
module sim_lamp_strike_sup;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int TMO   = 8;
    localparam int RETRY = 6;
    localparam int OVC   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ok = 1'b0, inv_ok = 1'b0, lamp_tick = 1'b1;
    logic [NCH-1:0] ch_en = '0, lamp_on = '0, lamp_out = '0;
    logic [NCH-1:0] over_cur = '0, over_volt = '0, regulated = '0;
    logic [1:0] tmo_sel = 2'd0;
    logic low_range = 1'b0, autoretry = 1'b1, oc_en = 1'b0, fault_all = 1'b0;
    logic [2:0] boost_sel = 3'd0;
    logic [NCH-1:0] gate_en, ch_fault;
    logic [NCH*7-1:0] boost_pct;
    logic fault_n;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int run_len = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lamp_strike_sup #(
        .NCH(NCH), .TMO_UNIT(TMO), .RETRY_CYC(RETRY), .OV_CYC(OVC), .FAULT_LIMIT(15)
    ) u0 (
        .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .inv_ok(inv_ok), .lamp_tick(lamp_tick),
        .ch_en(ch_en), .lamp_on(lamp_on), .lamp_out(lamp_out), .over_cur(over_cur),
        .over_volt(over_volt), .regulated(regulated), .tmo_sel(tmo_sel),
        .low_range(low_range), .autoretry(autoretry), .oc_en(oc_en),
        .fault_all(fault_all), .boost_sel(boost_sel), .gate_en(gate_en),
        .boost_pct(boost_pct), .ch_fault(ch_fault), .fault_n(fault_n)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: measures channel 0 gate pulses and pops expected strike lengths
    always @(negedge clk) begin
        if (!rst) begin
            if (gate_en[0]) begin
                run_len++;
            end else if (run_len != 0) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected ch0 pulse length", run_len, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk("R2 ch0 strike pulse length", run_len, e);
                end
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        step(3);
        chk("reset gate", int'(gate_en), 0);
        chk("reset fault_n", int'(fault_n), 1);
        rst = 1'b0;

        // R1: inverter supply low, no strike
        ch_en[0] = 1'b1; vcc_ok = 1'b1; inv_ok = 1'b0;
        step(20);
        chk("R1 no gate without inverter supply", int'(gate_en[0]), 0);

        // R2/R6: retry until the fifteenth fault
        autoretry = 1'b1; tmo_sel = 2'd0; low_range = 1'b0;
        for (int i = 0; i < 15; i++) exp_q.push_back(TMO);
        inv_ok = 1'b1;
        while (!gate_en[0]) step(1);
        while (gate_en[0]) step(1);
        chk("R12 fault_n low during retry wait", int'(fault_n), 0);
        chk("R6 flag set after first fault", int'(ch_fault[0]), 1);
        step(RETRY - 1);
        chk("R6 gate off through wait", int'(gate_en[0]), 0);
        step(1);
        chk("R6 restrike after wait", int'(gate_en[0]), 1);
        step(260);
        chk("R6 latched after limit", int'(ch_fault[0]), 1);
        chk("R6 gate off when latched", int'(gate_en[0]), 0);
        chk("R6 fifteen attempts seen", exp_q.size(), 0);
        chk("R12 fault_n low when latched", int'(fault_n), 0);

        // R9: clear via channel enable
        ch_en[0] = 1'b0;
        step(2);
        chk("R9 enable drop clears flag", int'(ch_fault[0]), 0);
        chk("R12 fault_n high after clear", int'(fault_n), 1);

        // R7/R2: no retry, long low-range timeout (4*8/2 = 16)
        autoretry = 1'b0; tmo_sel = 2'd3; low_range = 1'b1;
        exp_q.push_back(16);
        ch_en[0] = 1'b1;
        step(60);
        chk("R7 latched on first fault", int'(ch_fault[0]), 1);
        chk("R7 single attempt", exp_q.size(), 0);

        // R9: clear via device supply
        vcc_ok = 1'b0;
        step(2);
        chk("R9 supply drop clears flag", int'(ch_fault[0]), 0);
        ch_en[0] = 1'b0; vcc_ok = 1'b1;
        step(2);

        // R10: strike boost on channel 1
        tmo_sel = 2'd0; low_range = 1'b0; autoretry = 1'b1; boost_sel = 3'd3;
        ch_en[1] = 1'b1;
        step(1);
        chk("R10 gate on in strike", int'(gate_en[1]), 1);
        chk("R10 boost 33 percent in strike", int'(boost_pct[13:7]), 33);
        lamp_on[1] = 1'b1;
        step(1);
        chk("R10 boost back to 0 in run", int'(boost_pct[13:7]), 0);
        chk("R10 gate still on in run", int'(gate_en[1]), 1);

        // R3: lamp-out timeout in run
        step(3);
        lamp_out[1] = 1'b1;
        step(TMO - 1);
        chk("R3 gate on before lamp-out timeout", int'(gate_en[1]), 1);
        step(2);
        chk("R3 gate off after lamp-out timeout", int'(gate_en[1]), 0);
        chk("R12 fault_n low after lamp-out", int'(fault_n), 0);
        lamp_out[1] = 1'b0;
        step(RETRY + 3);
        chk("R6 channel 1 back in run", int'(gate_en[1]), 1);

        // R8: regulation clears the flag
        regulated[1] = 1'b1;
        step(2);
        chk("R8 flag cleared by regulation", int'(ch_fault[1]), 0);
        chk("R8 fault_n high after regulation", int'(fault_n), 1);

        // R4: short overvoltage burst ignored, full window faults
        over_volt[1] = 1'b1;
        step(OVC - 1);
        over_volt[1] = 1'b0;
        step(3);
        chk("R4 short overvoltage ignored", int'(gate_en[1]), 1);
        over_volt[1] = 1'b1;
        step(OVC - 1);
        chk("R4 gate on inside window", int'(gate_en[1]), 1);
        step(2);
        chk("R4 gate off after window", int'(gate_en[1]), 0);
        chk("R4 flag set", int'(ch_fault[1]), 1);
        over_volt[1] = 1'b0;
        step(RETRY + 3);
        chk("R4 channel 1 restruck", int'(gate_en[1]), 1);

        // R5: overcurrent on channel 2
        lamp_on[2] = 1'b1; ch_en[2] = 1'b1;
        step(3);
        chk("R5 channel 2 running", int'(gate_en[2]), 1);
        over_cur[2] = 1'b1;
        step(4);
        chk("R5 overcurrent ignored when disabled", int'(gate_en[2]), 1);
        oc_en = 1'b1;
        step(1);
        chk("R5 overcurrent stops gate", int'(gate_en[2]), 0);
        chk("R5 overcurrent sets flag", int'(ch_fault[2]), 1);
        step(RETRY + TMO + 5);
        chk("R5 no retry after overcurrent", int'(gate_en[2]), 0);
        over_cur[2] = 1'b0;

        // R11: local vs global fault response
        chk("R11 other channel unaffected", int'(gate_en[1]), 1);
        fault_all = 1'b1;
        step(1);
        chk("R11 global shutdown", int'(gate_en[1]), 0);
        step(3);
        chk("R11 shutdown holds", int'(gate_en[1]), 0);

        // R9: clear via inverter supply crossing
        inv_ok = 1'b0;
        step(2);
        chk("R9 inverter drop clears flags", int'(ch_fault), 0);
        chk("R12 fault_n high after clear", int'(fault_n), 1);
        inv_ok = 1'b1; fault_all = 1'b0;
        step(3);
        chk("R9 channel 2 restrikes after clear", int'(gate_en[2]), 1);

        done = 1'b1;
        summary();
    end
endmodule